// File: doc/BRIEF.md
# GPIO Event Detector with Maskable Interrupt

This block watches a 32-bit word of resolved pin input values and records, per pin, whether an event of the configured kind has happened. Each pin is configured as a level event (status is set on every cycle the input is high) or an edge event (status is set on a rising edge, or on either edge when the pin's both-edge bit is set). Recorded events are sticky until software clears them by writing ones to the status offset.

A per-pin enable register gates the status bits onto a single active-high interrupt line, which is the OR over all pins of status AND enable. The enable register can be written as a whole, or bits can be ORed in and ANDed out through separate set and clear aliases, so one pin can be masked without a read-modify-write. Event-type and both-edge configuration arrive as input words from the surrounding register file; the block decodes only the byte offsets it owns from a one-cycle write strobe.

Top module: `gpio_evt_irq`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the status and enable readbacks are 0 and irq is 0; the previous-input copy is loaded from din during reset, so an input held steady across reset release produces no edge event.
- R2: A pin whose event-type bit is 0 (level) has its status bit set at each clock edge where its din bit is 1; once set it stays set after din falls.
- R3: A pin whose event-type bit is 1 and both-edge bit is 0 sets its status bit only on a 0-to-1 change of din between consecutive clock edges; a falling change has no effect.
- R4: A pin whose event-type bit is 1 and both-edge bit is 1 sets its status bit on any change of din between consecutive clock edges.
- R5: A write to offset 0x4C clears every status bit whose write-data bit is 1 and leaves bits whose write-data bit is 0 unchanged.
- R6: When a clear and a new event hit the same status bit in the same cycle, the bit stays set; a level pin whose input is still high therefore cannot be cleared.
- R7: A write to offset 0x40 replaces the enable register, a write to 0x44 ORs the write data into it, and a write to 0x48 clears the enable bits whose write-data bit is 1.
- R8: irq is 1 exactly when some pin has both its status and enable bits set; a change caused by a write or an event is visible in the cycle after the clock edge that captured it.
- R9: Writes to any offset other than 0x40, 0x44, 0x48 and 0x4C change neither status nor enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 32 | Resolved per-pin input values |
| evt_type | input | 32 | Per pin: 0 level event, 1 edge event |
| evt_both | input | 32 | Per pin, edge mode only: 1 both edges, 0 rising only |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| evt_status | output | 32 | Sticky event status readback |
| evt_enable | output | 32 | Interrupt enable readback |
| irq | output | 1 | Active-high interrupt |

## Verification
On every cycle the assertions check that status bits only fall through an explicit clear, that every detected event lands in status on the next edge, that edge-type pins raise no event without an input change, that the set and clear aliases leave their bits set or cleared, and that setting an enable over a pending bit raises irq. Whether the detector picks the right edge polarity, the exact status words of the rising and both-edge sequences, the winning of an event over a colliding clear on a held-high level pin, replacement by a direct enable write, and the ignoring of foreign offsets are shown only by the bench's directed scenarios.

// File: rtl/gpio_evt_pkg.sv
// Package: shared offsets and sizes for the GPIO event/interrupt block.
// Assumes byte offsets on an 8-bit address; only word-aligned offsets decode.
package gpio_evt_pkg;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_ENABLE     = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_ENABLE_SET = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_ENABLE_CLR = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_STATUS     = 8'h4C;

    // Kind of write the block recognised on a given cycle.
    typedef enum logic [2:0] {
        WR_NONE,
        WR_EN_LOAD,
        WR_EN_SET,
        WR_EN_CLR,
        WR_ST_CLR
    } wr_kind_e;
endpackage

// File: rtl/gpio_evt_detect.sv
// Module: gpio_evt_detect
// Per-pin event detector. Produces a one-cycle event vector from the live
// input word, a registered copy of the previous input and the type words.
// Assumes din is already synchronous to clk. The previous copy tracks din
// during reset so that no edge is seen on reset release.
module gpio_evt_detect #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    input  logic [N-1:0] evt_type,
    input  logic [N-1:0] evt_both,
    output logic [N-1:0] evt
);
    logic [N-1:0] prev_q;

    // Hold last cycle's input; reset loads it from the live input.
    always_ff @(posedge clk) begin
        prev_q <= din;
    end

    // One detector slice per pin.
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic rise;
        logic fall;
        logic edge_hit;

        // Raw edge terms for this pin.
        always_comb begin
            rise     = din[i] & ~prev_q[i];
            fall     = ~din[i] & prev_q[i];
            edge_hit = rise | (evt_both[i] & fall);
        end

        // Select level or edge behaviour for this pin.
        always_comb begin
            if (evt_type[i]) begin
                evt[i] = edge_hit;
            end else begin
                evt[i] = din[i];
            end
        end
    end

    // R3 R4: an edge-type pin never flags an event without an input change
    no_silent_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((din ^ prev_q) & evt_type) == '0) |-> ((evt & evt_type) == '0));
endmodule

// File: rtl/gpio_evt_status.sv
// Module: gpio_evt_status
// Sticky per-pin status register. Events set bits; write-one-to-clear drops
// them. A new event in the same cycle as a clear keeps the bit set.
// Assumes clr_mask is zero on cycles without a status write.
module gpio_evt_status #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] status
);
    logic [N-1:0] status_q;
    logic [N-1:0] status_d;

    // Next state: keep uncleared bits, then merge new events on top.
    always_comb begin
        status_d = (status_q & ~clr_mask) | evt;
    end

    // Status storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status = status_q;

    // R5: a set bit only falls when its clear bit was written
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));

    // R2 R6: every detected event is recorded on the next edge
    event_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/gpio_evt_enable.sv
// Module: gpio_evt_enable
// Interrupt enable register with a direct load and separate OR-in and
// AND-out aliases. Assumes at most one of the three requests per cycle.
module gpio_evt_enable #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_req,
    input  logic         set_req,
    input  logic         clr_req,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] enable
);
    logic [N-1:0] en_q;
    logic [N-1:0] en_d;

    // Choose the next enable value from the active request.
    always_comb begin
        en_d = en_q;
        if (load_req) begin
            en_d = wdata;
        end else if (set_req) begin
            en_d = en_q | wdata;
        end else if (clr_req) begin
            en_d = en_q & ~wdata;
        end
    end

    // Enable storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign enable = en_q;

    // R7
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> ((en_q & $past(wdata)) == $past(wdata)));

    // R7
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> ((en_q & $past(wdata)) == '0));

    // R9
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_req || set_req || clr_req) |=> (en_q == $past(en_q)));
endmodule

// File: rtl/gpio_evt_irq.sv
// Module: gpio_evt_irq (top)
// GPIO event detection, sticky status and one maskable interrupt line.
// Decodes its own four offsets from a single-cycle write strobe; event type
// and both-edge words come from the surrounding register file.
// Assumes din is synchronous to clk and rst_n is synchronous active-low.
module gpio_evt_irq
    import gpio_evt_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      din,
    input  logic [N-1:0]      evt_type,
    input  logic [N-1:0]      evt_both,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N-1:0]      wr_data,
    output logic [N-1:0]      evt_status,
    output logic [N-1:0]      evt_enable,
    output logic              irq
);
    wr_kind_e     wr_kind;
    logic [N-1:0] evt;
    logic [N-1:0] st_clr_mask;
    logic         en_load;
    logic         en_set;
    logic         en_clr;
    logic [N-1:0] pending;

    // Classify the incoming write by offset.
    always_comb begin
        wr_kind = WR_NONE;
        if (wr_en) begin
            case (wr_addr)
                OFS_ENABLE:     wr_kind = WR_EN_LOAD;
                OFS_ENABLE_SET: wr_kind = WR_EN_SET;
                OFS_ENABLE_CLR: wr_kind = WR_EN_CLR;
                OFS_STATUS:     wr_kind = WR_ST_CLR;
                default:        wr_kind = WR_NONE;
            endcase
        end
    end

    // Fan the decoded write out to the two register slices.
    always_comb begin
        en_load     = (wr_kind == WR_EN_LOAD);
        en_set      = (wr_kind == WR_EN_SET);
        en_clr      = (wr_kind == WR_EN_CLR);
        st_clr_mask = (wr_kind == WR_ST_CLR) ? wr_data : '0;
    end

    gpio_evt_detect #(.N(N)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .evt_type (evt_type),
        .evt_both (evt_both),
        .evt      (evt)
    );

    gpio_evt_status #(.N(N)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr_mask (st_clr_mask),
        .status   (evt_status)
    );

    gpio_evt_enable #(.N(N)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (en_load),
        .set_req  (en_set),
        .clr_req  (en_clr),
        .wdata    (wr_data),
        .enable   (evt_enable)
    );

    // Combine status and enable into the single interrupt line.
    always_comb begin
        pending = evt_status & evt_enable;
        irq     = |pending;
    end

    // R8: enabling a pending pin raises irq on the next cycle
    irq_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set && |(wr_data & evt_status)) |=> irq);

    // R8: with no enable bits set the line stays low
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_enable == '0) |-> !irq);
endmodule

// File: tb/tb_gpio_evt_irq.sv
module tb_gpio_evt_irq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] din = '0;
    logic [31:0] evt_type = '0;
    logic [31:0] evt_both = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] evt_status;
    logic [31:0] evt_enable;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    gpio_evt_irq dut (
        .clk(clk), .rst_n(rst_n), .din(din), .evt_type(evt_type),
        .evt_both(evt_both), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_status(evt_status),
        .evt_enable(evt_enable), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One bus write; results are visible at the returning negedge.
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    // Apply a new input word; status reflects it at the returning negedge.
    task automatic set_din(input logic [31:0] v);
        @(negedge clk);
        din = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        evt_type = 32'hFFFF_FFFF; evt_both = '0; din = 32'hFFFF_0000;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 status after reset", evt_status, 32'h0);
        chk("R1 enable after reset", evt_enable, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        repeat (2) @(negedge clk);
        chk("R1 no event on reset release", evt_status, 32'h0);
    endtask

    task automatic t_rising;
        set_din(32'hFF00_FF00);
        chk("R3 rising only", evt_status, 32'h0000_FF00);
        set_din(32'h00FF_0000);
        chk("R3 falling ignored", evt_status, 32'h00FF_FF00);
        bus_wr(8'h4C, 32'h0000_F000);
        chk("R5 partial clear", evt_status, 32'h00FF_0F00);
        bus_wr(8'h4C, 32'h00FF_0F00);
        chk("R5 full clear", evt_status, 32'h0);
    endtask

    task automatic t_both;
        evt_both = 32'hFFFF_FFFF;
        set_din(32'hFFFF_0000);
        bus_wr(8'h4C, 32'hFFFF_FFFF);
        chk("R4 baseline cleared", evt_status, 32'h0);
        set_din(32'hFF00_FF00);
        chk("R4 both edges step1", evt_status, 32'h00FF_FF00);
        set_din(32'hEF00_FF08);
        chk("R4 both edges step2", evt_status, 32'h10FF_FF08);
        bus_wr(8'h4C, 32'hFFFF_FFFF);
        chk("R4 cleared after", evt_status, 32'h0);
    endtask

    task automatic t_level;
        @(negedge clk);
        evt_type = '0; evt_both = '0; din = 32'hBA98_7654;
        @(negedge clk);
        chk("R2 level set", evt_status, 32'hBA98_7654);
        set_din(32'h0);
        chk("R2 level sticky after low", evt_status, 32'hBA98_7654);
        bus_wr(8'h4C, 32'h0000_7654);
        chk("R5 level partial clear", evt_status, 32'hBA98_0000);
        bus_wr(8'h4C, 32'hBA98_0000);
        chk("R5 level clear", evt_status, 32'h0);
        set_din(32'h0000_0001);
        bus_wr(8'h4C, 32'h0000_0001);
        chk("R6 event beats clear", evt_status, 32'h0000_0001);
        set_din(32'h0);
        bus_wr(8'h4C, 32'h0000_0001);
        chk("R6 clear after input low", evt_status, 32'h0);
    endtask

    task automatic t_enable;
        bus_wr(8'h40, 32'h0000_FFFF);
        chk("R7 direct load", evt_enable, 32'h0000_FFFF);
        bus_wr(8'h44, 32'hFF00_0000);
        chk("R7 set alias", evt_enable, 32'hFF00_FFFF);
        bus_wr(8'h48, 32'h0000_00FF);
        chk("R7 clear alias", evt_enable, 32'hFF00_FF00);
        bus_wr(8'h40, 32'h0000_0012);
        chk("R7 load replaces", evt_enable, 32'h0000_0012);
    endtask

    task automatic t_ignored;
        bus_wr(8'h4C, 32'h0000_0000);
        set_din(32'h0000_0100);
        set_din(32'h0);
        bus_wr(8'h50, 32'hFFFF_FFFF);
        chk("R9 status untouched", evt_status, 32'h0000_0100);
        chk("R9 enable untouched", evt_enable, 32'h0000_0012);
        bus_wr(8'h28, 32'h0);
        chk("R9 enable untouched 2", evt_enable, 32'h0000_0012);
        bus_wr(8'h4C, 32'hFFFF_FFFF);
        chk("R5 clear before irq", evt_status, 32'h0);
    endtask

    task automatic t_irq;
        bus_wr(8'h40, 32'h0);
        set_din(32'h0000_8000);
        chk("R8 masked pending", {31'b0, irq}, 32'h0);
        bus_wr(8'h44, 32'h0000_8000);
        chk("R8 enable raises", {31'b0, irq}, 32'h1);
        bus_wr(8'h48, 32'h0000_8000);
        chk("R8 enable clear drops", {31'b0, irq}, 32'h0);
        bus_wr(8'h44, 32'h0000_8000);
        chk("R8 re-enable raises", {31'b0, irq}, 32'h1);
        bus_wr(8'h4C, 32'h0000_8000);
        chk("R8 level still high keeps irq", {31'b0, irq}, 32'h1);
        set_din(32'h0);
        bus_wr(8'h4C, 32'h0000_8000);
        chk("R8 clear drops irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_rising();
        t_both();
        t_level();
        t_enable();
        t_ignored();
        t_irq();
        done = 1'b1;
        summary();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end
endmodule